// File: doc/BRIEF.md
# Sixty-Four Input Interrupt Controller

This block gathers 64 interrupt request inputs and presents them to a processor as two main request lines (a normal request and a fast request) plus six auxiliary destination lines. Each input has its own configuration byte on a small word-wide register bus. The byte turns the input on or off, chooses level or edge sensing, and picks one of eight destinations.

Inputs are brought into the clock domain by a two-stage synchronizer before any sensing takes place. Edge-sensed inputs capture their event in a pending latch, and software releases that latch by writing a one. Each of the two main request lines has a priority register. Reading it returns the number of the winning source. The search order is either fixed, with the lowest number first, or rotating, where each read that returns a valid winner moves the starting point to the source after that winner.

Top module: `src_intc`

## Requirements
- R1: After reset every configuration byte reads 0x00 (disabled, level, destination 0), both status words read zero, all output lines are low, the request-line priority register (byte address 0x20) reads 0x40 (rotating on) and the fast-line priority register (0x24) reads 0x00 (fixed).
- R2: Source i owns byte lane i mod 4 of the word at byte address 0x40 + 4*(i div 4). In that byte, bit 3 is the enable, bits 6:5 the trigger and bits 2:0 the destination code. Bits 7 and 4 read as zero. A write changes only the lanes whose byte enable is set.
- R3: With trigger 00, a source is pending while its synchronized input is high. It drives its destination only while its enable bit is set.
- R4: Trigger bit 5 latches a synchronized rising edge and trigger bit 6 latches a falling edge. The latch sets whether or not the source is enabled. Latches for sources 0-31 read at byte address 0x80 and those for 32-63 at 0x84, with source i at bit i mod 32. A latched source drives its destination only while it is enabled.
- R5: Writing a one to a status bit clears that latch, and writing a zero leaves it unchanged. When a new edge and a clearing write for the same latch arrive in the same cycle, the latch stays set.
- R6: Destination code 0 drives irq_o, code 1 drives fiq_o, and codes 2 to 7 drive aux_o[0] to aux_o[5]. Each line is the OR of all enabled, pending sources carrying its code.
- R7: A priority register (0x20 for code 0, 0x24 for code 1) reads {valid, rotate, winner[5:0]} in bits 7:0. When no source is pending the valid bit and the winner field read as zero. Only bit 6 is writable; writes to bits 7 and 5:0 have no effect.
- R8: In fixed mode the winner is the lowest-numbered enabled, pending source of that destination. Reading the register does not change later results.
- R9: In rotating mode, a read that returns a valid winner w makes the next search start at w+1, wrapping from 63 to 0. The start point is kept while the port is in fixed mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 64 | Asynchronous interrupt inputs, one per source |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address; must be word aligned (low two bits zero) |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq_o | output | 1 | Normal request line (destination code 0) |
| fiq_o | output | 1 | Fast request line (destination code 1) |
| aux_o | output | 6 | Auxiliary lines (destination codes 2 to 7) |

## Verification
The interaction most likely to go wrong is a new edge arriving on a source in the same clock cycle that software writes a one to clear that source's pending latch. The bench first latches the source and drops its input. It then raises the input again and times the clearing write so that the bus edge sampling the write is the same edge at which the synchronizer delivers the new rise. The status word read afterwards must still show the bit set. A separate clearing write with no edge in flight then shows that the same write does clear the latch.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;

    // Number of destination codes held in a configuration byte.
    localparam int unsigned DEST_CODES = 8;
    // Ports with a readable priority register: code 0 and code 1.
    localparam int unsigned PRIO_PORTS = 2;

    // Word addresses (byte address divided by four).
    localparam int unsigned WORD_PRIO = 8;   // 0x20, 0x24
    localparam int unsigned WORD_CFG  = 16;  // 0x40 .. 0x7C
    localparam int unsigned WORD_STAT = 32;  // 0x80, 0x84

    // Bit in a priority register that selects rotating search.
    localparam int unsigned ROT_BIT = 6;

    typedef struct packed {
        logic [1:0] trig;   // [0] rising, [1] falling, 00 level
        logic       en;
        logic [2:0] dest;
    } src_cfg_t;

    function automatic src_cfg_t cfg_from_byte(input logic [7:0] b);
        src_cfg_t c;
        c.trig = b[6:5];
        c.en   = b[3];
        c.dest = b[2:0];
        return c;
    endfunction

    function automatic logic [7:0] cfg_to_byte(input src_cfg_t c);
        return {1'b0, c.trig, 1'b0, c.en, c.dest};
    endfunction

endpackage

// File: rtl/intc_sync.sv
`timescale 1ns/1ps
module intc_sync #(
    parameter int unsigned WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
        logic [WIDTH-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.meta   = raw_i;
        sync_d.stable = sync_q.meta;
        sync_d.prev   = sync_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign level_o = sync_q.stable;
    assign rise_o  = sync_q.stable & ~sync_q.prev;
    assign fall_o  = ~sync_q.stable & sync_q.prev;

endmodule

// File: rtl/intc_pick.sv
`timescale 1ns/1ps
module intc_pick #(
    parameter int unsigned WIDTH = 64,
    parameter int unsigned IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] cand_i,
    input  logic [IDX_W-1:0] start_i,
    output logic             hit_o,
    output logic [IDX_W-1:0] win_o
);

    logic [2*WIDTH-1:0] doubled;
    logic [WIDTH-1:0]   rotated;
    logic [IDX_W-1:0]   offs;
    logic [IDX_W:0]     sum;

    always_comb begin
        // Rotate so that the start index lands on bit 0.
        doubled = {cand_i, cand_i} >> start_i;
        rotated = doubled[WIDTH-1:0];
        offs    = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (rotated[i]) begin
                offs = IDX_W'(i);
            end
        end
        sum = {1'b0, offs} + {1'b0, start_i};
        if (sum >= (IDX_W + 1)'(WIDTH)) begin
            sum = sum - (IDX_W + 1)'(WIDTH);
        end
        hit_o = |cand_i;
        win_o = sum[IDX_W-1:0];
    end

endmodule

// File: rtl/src_intc.sv
`timescale 1ns/1ps
module src_intc
    import intc_pkg::*;
#(
    parameter int unsigned N_SRC  = 64,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_in,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              fiq_o,
    output logic [DEST_CODES-3:0] aux_o
);

    localparam int unsigned IDX_W      = $clog2(N_SRC);
    localparam int unsigned LANES      = DATA_W / 8;
    localparam int unsigned WA_W       = ADDR_W - 2;
    localparam int unsigned STAT_WORDS = N_SRC / DATA_W;
    localparam int unsigned CFG_WORDS  = N_SRC / LANES;

    typedef struct packed {
        src_cfg_t [N_SRC-1:0]                cfg;
        logic [N_SRC-1:0]                    latch;
        logic [PRIO_PORTS-1:0]               rot;
        logic [PRIO_PORTS-1:0][IDX_W-1:0]    start;
    } state_t;

    function automatic state_t reset_state();
        state_t s;
        s        = '0;
        s.rot[0] = 1'b1;   // request line rotates, fast line fixed
        return s;
    endfunction

    function automatic logic [IDX_W-1:0] next_idx(input logic [IDX_W-1:0] w);
        return (w == IDX_W'(N_SRC - 1)) ? '0 : w + 1'b1;
    endfunction

    state_t st_d, st_q;

    logic [N_SRC-1:0] lvl, rise, fall;
    logic [N_SRC-1:0] en_vec, pend, set_vec, clr_vec;
    logic [DEST_CODES-1:0][N_SRC-1:0] cand;
    logic [DEST_CODES-1:0] line;
    logic [PRIO_PORTS-1:0] pick_hit;
    logic [PRIO_PORTS-1:0][IDX_W-1:0] pick_win;
    logic [WA_W-1:0] wa;
    logic aligned, wr_en, rd_en;

    // ---------------- input conditioning ----------------
    intc_sync #(.WIDTH(N_SRC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   (src_in),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    always_comb begin
        for (int i = 0; i < N_SRC; i++) begin
            en_vec[i]  = st_q.cfg[i].en;
            set_vec[i] = (st_q.cfg[i].trig[0] & rise[i]) |
                         (st_q.cfg[i].trig[1] & fall[i]);
            pend[i]    = (st_q.cfg[i].trig == 2'b00) ? lvl[i] : st_q.latch[i];
        end
    end

    // ---------------- routing per destination ----------------
    for (genvar g = 0; g < DEST_CODES; g++) begin : g_dest
        logic [N_SRC-1:0] hits;
        always_comb begin
            for (int i = 0; i < N_SRC; i++) begin
                hits[i] = en_vec[i] & pend[i] & (st_q.cfg[i].dest == 3'(g));
            end
        end
        assign cand[g] = hits;
        assign line[g] = |hits;
    end

    assign irq_o = line[0];
    assign fiq_o = line[1];
    assign aux_o = line[DEST_CODES-1:2];

    // ---------------- priority search per port ----------------
    for (genvar p = 0; p < PRIO_PORTS; p++) begin : g_prio
        logic [IDX_W-1:0] from;
        assign from = st_q.rot[p] ? st_q.start[p] : '0;
        intc_pick #(.WIDTH(N_SRC), .IDX_W(IDX_W)) u_pick (
            .cand_i  (cand[p]),
            .start_i (from),
            .hit_o   (pick_hit[p]),
            .win_o   (pick_win[p])
        );
    end

    // ---------------- bus decode ----------------
    assign wa      = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_en   = bus_sel & bus_we & aligned;
    assign rd_en   = bus_sel & ~bus_we & aligned;

    always_comb begin
        clr_vec = '0;
        for (int k = 0; k < STAT_WORDS; k++) begin
            if (wr_en && wa == WA_W'(WORD_STAT + k)) begin
                for (int b = 0; b < LANES; b++) begin
                    if (bus_be[b]) begin
                        clr_vec[k*DATA_W + b*8 +: 8] = bus_wdata[b*8 +: 8];
                    end
                end
            end
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        // A fresh edge outranks a clearing write in the same cycle.
        st_d.latch = (st_q.latch & ~clr_vec) | set_vec;
        for (int i = 0; i < N_SRC; i++) begin
            if (wr_en && wa == WA_W'(WORD_CFG + i / LANES) && bus_be[i % LANES]) begin
                st_d.cfg[i] = cfg_from_byte(bus_wdata[(i % LANES)*8 +: 8]);
            end
        end
        for (int p = 0; p < PRIO_PORTS; p++) begin
            if (wr_en && wa == WA_W'(WORD_PRIO + p) && bus_be[0]) begin
                st_d.rot[p] = bus_wdata[ROT_BIT];
            end
            if (rd_en && wa == WA_W'(WORD_PRIO + p) && st_q.rot[p] && pick_hit[p]) begin
                st_d.start[p] = next_idx(pick_win[p]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= reset_state();
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- read mux ----------------
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            for (int p = 0; p < PRIO_PORTS; p++) begin
                if (wa == WA_W'(WORD_PRIO + p)) begin
                    bus_rdata[IDX_W+1:0] = {pick_hit[p], st_q.rot[p],
                                            pick_hit[p] ? pick_win[p] : IDX_W'(0)};
                end
            end
            for (int k = 0; k < CFG_WORDS; k++) begin
                if (wa == WA_W'(WORD_CFG + k)) begin
                    for (int b = 0; b < LANES; b++) begin
                        bus_rdata[b*8 +: 8] = cfg_to_byte(st_q.cfg[k*LANES + b]);
                    end
                end
            end
            for (int k = 0; k < STAT_WORDS; k++) begin
                if (wa == WA_W'(WORD_STAT + k)) begin
                    bus_rdata = st_q.latch[k*DATA_W +: DATA_W];
                end
            end
        end
    end

endmodule

// File: rtl/intc_chk.sv
`timescale 1ns/1ps
module intc_chk #(
    parameter int unsigned N  = 64,
    parameter int unsigned IW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  cand_irq,
    input logic [N-1:0]  cand_fiq,
    input logic [1:0]    hit,
    input logic [IW-1:0] win_irq,
    input logic [IW-1:0] win_fiq,
    input logic [1:0]    rot,
    input logic          irq_o,
    input logic          fiq_o
);

    logic [N-1:0] below_fiq;
    assign below_fiq = (N'(1) << win_fiq) - N'(1);

    // R6
    irq_line_agrees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit[0] == irq_o);

    // R6
    fiq_line_agrees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit[1] == fiq_o);

    // R7
    irq_winner_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit[0] |-> cand_irq[win_irq]);

    // R7
    fiq_winner_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit[1] |-> cand_fiq[win_fiq]);

    // R8
    fiq_fixed_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[1] && !rot[1]) |-> ((cand_fiq & below_fiq) == '0));

endmodule

bind src_intc intc_chk #(.N(N_SRC), .IW(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cand_irq (cand[0]),
    .cand_fiq (cand[1]),
    .hit      (pick_hit),
    .win_irq  (pick_win[0]),
    .win_fiq  (pick_win[1]),
    .rot      (st_q.rot),
    .irq_o    (irq_o),
    .fiq_o    (fiq_o)
);

// File: tb/src_intc_tb.sv
`timescale 1ns/1ps
module src_intc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;
    logic [5:0]  aux_o;
    logic        pin_chk = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_pin;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sbq[$];

    always #2 clk = ~clk;   // 250 MHz

    src_intc u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o),
        .fiq_o     (fiq_o),
        .aux_o     (aux_o)
    );

    // Monitor: pops one expected item per observed result.
    always @(negedge clk) begin
        item_t       it;
        logic [31:0] act;
        if ((bus_sel && !bus_we) || pin_chk) begin
            checks++;
            if (sbq.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: actual result with no expectation, expected queued item");
            end else begin
                it  = sbq.pop_front();
                act = it.is_pin ? {24'd0, aux_o, fiq_o, irq_o} : bus_rdata;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_we = 1'b0; bus_be = '0;
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string req);
        item_t it;
        @(posedge clk); #1;
        it.is_pin = 1'b0; it.exp = e; it.req = req;
        sbq.push_back(it);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    // Expected pins: {aux[5:0], fiq, irq}
    task automatic expect_pins(input logic [7:0] e, input string req);
        item_t it;
        @(posedge clk); #1;
        it.is_pin = 1'b1; it.exp = {24'd0, e}; it.req = req;
        sbq.push_back(it);
        pin_chk = 1'b1;
        @(posedge clk); #1;
        pin_chk = 1'b0;
    endtask

    task automatic wr_cfg(input int i, input logic [7:0] b);
        bus_wr(8'(8'h40 + 4 * (i / 4)), 4'(1 << (i % 4)), 32'(b) << (8 * (i % 4)));
    endtask

    task automatic set_src(input int i, input logic v);
        @(posedge clk); #1;
        src_in[i] = v;
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
    endtask

    task automatic pulse(input int i);
        set_src(i, 1'b1); settle();
        set_src(i, 1'b0); settle();
    endtask

    task automatic cleanup();
        for (int k = 0; k < 16; k++) bus_wr(8'(8'h40 + 4 * k), 4'hF, 32'h0);
        @(posedge clk); #1;
        src_in = '0;
        settle();
        bus_wr(8'h80, 4'hF, 32'hFFFF_FFFF);
        bus_wr(8'h84, 4'hF, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual still running, expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_rd(8'h20, 32'h40, "R1 irq prio reset");
        expect_rd(8'h24, 32'h00, "R1 fiq prio reset");
        expect_rd(8'h40, 32'h0, "R1 cfg word 0 reset");
        expect_rd(8'h7C, 32'h0, "R1 cfg word 15 reset");
        expect_rd(8'h84, 32'h0, "R1 status high reset");
        expect_pins(8'h00, "R1 lines low");

        // R2 / R3 level source on the request line
        wr_cfg(5, 8'h08);
        expect_rd(8'h44, 32'h0000_0800, "R2 cfg readback");
        set_src(5, 1'b1); settle();
        expect_pins(8'h01, "R3 level drives irq");
        expect_rd(8'h20, 32'hC5, "R7 irq winner 5");        // start becomes 6
        set_src(5, 1'b0); settle();
        expect_pins(8'h00, "R3 level released");
        set_src(5, 1'b1);
        wr_cfg(5, 8'h00); settle();
        expect_pins(8'h00, "R3 disabled source masked");
        expect_rd(8'h20, 32'h40, "R7 no winner reads zero field");

        // R2 byte lanes and unused bits
        wr_cfg(4, 8'h09);
        wr_cfg(6, 8'hD2);
        expect_rd(8'h44, 32'h0042_0009, "R2 lane isolation and reserved bits");
        cleanup();

        // R6 routing
        wr_cfg(10, 8'h09);
        wr_cfg(20, 8'h0C);
        wr_cfg(63, 8'h0F);
        set_src(10, 1'b1); set_src(20, 1'b1); set_src(63, 1'b1); settle();
        expect_pins(8'h92, "R6 fiq aux2 aux5");
        set_src(20, 1'b0); settle();
        expect_pins(8'h82, "R6 aux2 released");
        cleanup();

        // R4 / R5 edges
        wr_cfg(33, 8'h28);
        pulse(33);
        expect_rd(8'h84, 32'h0000_0002, "R4 rising latched");
        expect_pins(8'h01, "R4 latch drives irq after input low");
        bus_wr(8'h84, 4'hF, 32'h0);
        expect_rd(8'h84, 32'h0000_0002, "R5 write zero keeps latch");
        bus_wr(8'h84, 4'hF, 32'h2);
        expect_rd(8'h84, 32'h0, "R5 write one clears");
        expect_pins(8'h00, "R5 irq drops after clear");
        wr_cfg(40, 8'h48);
        set_src(40, 1'b1); settle();
        expect_rd(8'h84, 32'h0, "R4 falling ignores rise");
        set_src(40, 1'b0); settle();
        expect_rd(8'h84, 32'h0000_0100, "R4 falling latched");
        bus_wr(8'h84, 4'hF, 32'h100);
        wr_cfg(34, 8'h20);
        pulse(34);
        expect_rd(8'h84, 32'h0000_0004, "R4 latch while disabled");
        expect_pins(8'h00, "R4 disabled latch masked");
        wr_cfg(34, 8'h28);
        expect_pins(8'h01, "R4 enable exposes latch");
        wr_cfg(0, 8'h28);
        pulse(0);
        expect_rd(8'h80, 32'h0000_0001, "R4 low status word");
        cleanup();

        // R5 set and clear in the same cycle
        wr_cfg(35, 8'h20);
        pulse(35);
        expect_rd(8'h84, 32'h0000_0008, "R5 pre-latched");
        set_src(35, 1'b1);
        @(posedge clk);
        bus_wr(8'h84, 4'hF, 32'h8);      // sampled with the rise
        settle();
        expect_rd(8'h84, 32'h0000_0008, "R5 new edge beats clear");
        bus_wr(8'h84, 4'hF, 32'h8);
        expect_rd(8'h84, 32'h0, "R5 clear without edge");
        cleanup();

        // R8 fixed priority on the fast line
        wr_cfg(3, 8'h09);
        wr_cfg(50, 8'h09);
        set_src(3, 1'b1); set_src(50, 1'b1); settle();
        expect_rd(8'h24, 32'h83, "R8 lowest wins");
        expect_rd(8'h24, 32'h83, "R8 read does not rotate");
        set_src(3, 1'b0); settle();
        expect_rd(8'h24, 32'hB2, "R8 next lowest");
        cleanup();

        // R9 rotating priority (start is 6 from the earlier read)
        wr_cfg(2, 8'h08);
        wr_cfg(7, 8'h08);
        wr_cfg(60, 8'h08);
        set_src(2, 1'b1); set_src(7, 1'b1); set_src(60, 1'b1); settle();
        expect_rd(8'h20, 32'hC7, "R9 from 6 picks 7");
        expect_rd(8'h20, 32'hFC, "R9 from 8 picks 60");
        expect_rd(8'h20, 32'hC2, "R9 wraps to 2");
        expect_rd(8'h20, 32'hC7, "R9 from 3 picks 7");
        bus_wr(8'h20, 4'h1, 32'hBF);
        expect_rd(8'h20, 32'h82, "R7 only rotate bit writable");
        expect_rd(8'h20, 32'h82, "R8 fixed stable");
        bus_wr(8'h20, 4'h1, 32'h40);
        expect_rd(8'h20, 32'hFC, "R9 start kept through fixed mode");
        cleanup();

        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule